// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the single-cycle bookkeeping that a simple 32-bit RISC core needs when it enters an exception handler. In a given cycle the core can present a synchronous exception request with a cause code. The unit also watches two interrupt lines: one from an external device and one from the tick timer. It picks one event, or none. In the next cycle it presents a one-cycle "taken" pulse together with the handler address, the saved return address, the saved status, the rewritten status and power-management values, and a pulse that kills any load-link reservation.

The return address is corrected for two cases. A system call resumes after the trapping instruction. An exception on an instruction in a branch delay slot resumes at the branch. The handler address is the cause number shifted into bits 8 and up. It is OR-combined with a configurable base address when that base is enabled, and with a fixed high-memory prefix when the status register's high-vector bit is set. A cause code outside the valid range does not vector and raises an error pulse instead.

The control is a three-state machine. ST_IDLE means nothing was accepted last cycle. ST_TAKEN means an event was accepted last cycle. ST_FAULT means an invalid synchronous cause was seen last cycle. From any state the machine moves to ST_TAKEN on an accepted event (transition ACCEPT), to ST_FAULT on an invalid cause (transition REJECT), and otherwise to ST_IDLE (transition QUIET).

Top module: `exc_entry_unit`

## Requirements
- R1: On a taken event, `epcr` becomes the current PC. For cause 12 (system call) it becomes PC + 4.
- R2: On a taken cause 7 (illegal instruction), `eear` becomes the current PC. Every other event leaves `eear` unchanged.
- R3: On a taken event, `esr` becomes the full status word as it was in the request cycle.
- R4: Status bits are SM=bit 0, TEE=bit 1, IEE=bit 2, DMMU=bit 3, IMMU=bit 4, HIVEC=bit 5 and DSX=bit 6. On a taken event, `sr_new` equals the input status with TEE, IEE, DMMU and IMMU cleared and SM set. All other bits except DSX keep their values.
- R5: Power-management bits are doze=bit 0 and sleep=bit 1. On a taken event, `pmr_new` equals the input with both of these bits cleared and all other bits kept.
- R6: `resv_kill` pulses high in exactly the cycle `exc_taken` is high.
- R7: If `in_dslot` was high in the request cycle, then DSX of `sr_new` is set, `epcr` is reduced by 4 and `dslot_clear` pulses with `exc_taken`. Otherwise DSX is cleared and `dslot_clear` stays low.
- R8: `new_pc` = (cause << 8), ORed with `vec_base` when `vec_base_en` is high, and ORed with 0xF0000000 when the input status bit HIVEC is set.
- R9: Without a synchronous request, the tick interrupt (cause 5) is taken only if TEE is set. The external interrupt (cause 8) is taken only if IEE is set. When both are eligible, the tick interrupt wins.
- R10: A synchronous cause of 0 or 15 produces a one-cycle `exc_err` pulse and no `exc_taken`. It leaves every saved and presented value unchanged.
- R11: `exc_taken` is a one-cycle pulse in the cycle after the accepting edge, and `taken_cause` gives the event. A synchronous request beats any interrupt in the same cycle.
- R12: After reset every output is zero and the state is ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request, one cycle |
| exc_cause | input | 4 | Cause code of the synchronous request |
| cur_pc | input | 32 | PC of the current instruction |
| cur_sr | input | 32 | Current status word |
| cur_pmr | input | 8 | Current power-management word |
| in_dslot | input | 1 | Current instruction sits in a delay slot |
| vec_base | input | 32 | Vector base address |
| vec_base_en | input | 1 | Enables use of the vector base |
| irq_ext | input | 1 | External device interrupt pending |
| irq_tick | input | 1 | Tick-timer interrupt pending |
| exc_taken | output | 1 | Event accepted last cycle |
| exc_err | output | 1 | Invalid cause seen last cycle |
| taken_cause | output | 4 | Cause of the last accepted event |
| new_pc | output | 32 | Handler address |
| epcr | output | 32 | Saved return address |
| eear | output | 32 | Saved effective address |
| esr | output | 32 | Saved status word |
| sr_new | output | 32 | Rewritten status word |
| pmr_new | output | 8 | Rewritten power-management word |
| resv_kill | output | 1 | Invalidate load-link reservation |
| dslot_clear | output | 1 | Clear the core's delay-slot flag |

## Verification
On every cycle the assertions check the following. The saved status matches the status of the previous cycle. A plain entry saves the previous PC. A taken event always leaves supervisor mode set, both interrupt enables cleared and both power-saving bits cleared. An error cycle leaves the return address untouched. A synchronous request shows up as the reported cause. Vector bits below 8 are clear when the base is off. A tick grant never happens with its enable clear. Other properties need the bench's sweeps over all sixteen cause codes and the delay-slot, base and high-vector settings: the exact arithmetic of the vector and return address, `eear` holding across non-illegal events, and the interrupt arbitration over all enable combinations.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TAKEN = 2'd1,
        ST_FAULT = 2'd2
    } exc_state_e;

    // cause numbers the unit treats specially
    localparam int CAUSE_TICK    = 5;
    localparam int CAUSE_ILLEGAL = 7;
    localparam int CAUSE_EXTINT  = 8;
    localparam int CAUSE_SYSCALL = 12;

    // status word bit positions
    localparam int SRB_SM    = 0;
    localparam int SRB_TEE   = 1;
    localparam int SRB_IEE   = 2;
    localparam int SRB_DMMU  = 3;
    localparam int SRB_IMMU  = 4;
    localparam int SRB_HIVEC = 5;
    localparam int SRB_DSX   = 6;

    // power-management bit positions
    localparam int PMB_DOZE  = 0;
    localparam int PMB_SLEEP = 1;

endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
    import exc_pkg::*;
#(
    parameter int CAUSE_W     = 4,
    parameter int CAUSE_COUNT = 15
) (
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               irq_ext,
    input  logic               irq_tick,
    input  logic               sr_iee,
    input  logic               sr_tee,
    output logic               sel_fire,
    output logic               sel_bad,
    output logic [CAUSE_W-1:0] sel_cause
);
    localparam int CNT_W = CAUSE_W + 1;
    localparam logic [CNT_W-1:0]   LIMIT  = CNT_W'(CAUSE_COUNT);
    localparam logic [CAUSE_W-1:0] C_TICK = CAUSE_W'(CAUSE_TICK);
    localparam logic [CAUSE_W-1:0] C_EXT  = CAUSE_W'(CAUSE_EXTINT);

    logic code_ok;
    assign code_ok = (exc_cause != '0) && ({1'b0, exc_cause} < LIMIT);

    always_comb begin
        sel_fire  = 1'b0;
        sel_bad   = 1'b0;
        sel_cause = '0;
        if (exc_req) begin
            sel_cause = exc_cause;
            if (code_ok) sel_fire = 1'b1;
            else         sel_bad  = 1'b1;
        end else if (irq_tick && sr_tee) begin
            sel_fire  = 1'b1;
            sel_cause = C_TICK;
        end else if (irq_ext && sr_iee) begin
            sel_fire  = 1'b1;
            sel_cause = C_EXT;
        end
    end

    always_comb begin
        if (sel_fire && !exc_req && (sel_cause == C_TICK))
            AST_TICK_NEEDS_TEE: assert (irq_tick && sr_tee); // R9
        if (sel_fire && !exc_req && (sel_cause == C_EXT))
            AST_EXT_NEEDS_IEE: assert (irq_ext && sr_iee && !(irq_tick && sr_tee)); // R9
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
    parameter int               XLEN      = 32,
    parameter int               CAUSE_W   = 4,
    parameter int               VEC_SHIFT = 8,
    parameter logic [XLEN-1:0]  HI_PREFIX = 32'hF000_0000
) (
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    base,
    input  logic               base_en,
    input  logic               hivec,
    output logic [XLEN-1:0]    vec
);
    logic [XLEN-1:0] slot;

    assign slot = XLEN'(cause) << VEC_SHIFT;

    always_comb begin
        vec = slot;
        if (base_en) vec = vec | base;
        if (hivec)   vec = vec | HI_PREFIX;
    end

endmodule

// File: rtl/exc_state_upd.sv
module exc_state_upd
    import exc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int PMR_W = 8
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  sr,
    input  logic [PMR_W-1:0] pmr,
    input  logic             dslot,
    input  logic             is_syscall,
    output logic [XLEN-1:0]  epc_nxt,
    output logic [XLEN-1:0]  sr_nxt,
    output logic [PMR_W-1:0] pmr_nxt
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] fwd;
    logic [XLEN-1:0] back;

    assign fwd     = is_syscall ? STEP : '0;
    assign back    = dslot      ? STEP : '0;
    assign epc_nxt = pc + fwd - back;

    always_comb begin
        sr_nxt           = sr;
        sr_nxt[SRB_TEE]  = 1'b0;
        sr_nxt[SRB_IEE]  = 1'b0;
        sr_nxt[SRB_DMMU] = 1'b0;
        sr_nxt[SRB_IMMU] = 1'b0;
        sr_nxt[SRB_SM]   = 1'b1;
        sr_nxt[SRB_DSX]  = dslot;
    end

    always_comb begin
        pmr_nxt            = pmr;
        pmr_nxt[PMB_DOZE]  = 1'b0;
        pmr_nxt[PMB_SLEEP] = 1'b0;
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              CAUSE_W     = 4,
    parameter int              CAUSE_COUNT = 15,
    parameter int              VEC_SHIFT   = 8,
    parameter int              PMR_W       = 8,
    parameter logic [XLEN-1:0] HI_PREFIX   = 32'hF000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    cur_sr,
    input  logic [PMR_W-1:0]   cur_pmr,
    input  logic               in_dslot,
    input  logic [XLEN-1:0]    vec_base,
    input  logic               vec_base_en,
    input  logic               irq_ext,
    input  logic               irq_tick,
    output logic               exc_taken,
    output logic               exc_err,
    output logic [CAUSE_W-1:0] taken_cause,
    output logic [XLEN-1:0]    new_pc,
    output logic [XLEN-1:0]    epcr,
    output logic [XLEN-1:0]    eear,
    output logic [XLEN-1:0]    esr,
    output logic [XLEN-1:0]    sr_new,
    output logic [PMR_W-1:0]   pmr_new,
    output logic               resv_kill,
    output logic               dslot_clear
);
    localparam logic [CAUSE_W-1:0] C_ILL = CAUSE_W'(CAUSE_ILLEGAL);
    localparam logic [CAUSE_W-1:0] C_SYS = CAUSE_W'(CAUSE_SYSCALL);

    exc_state_e state_q, state_d;

    logic               sel_fire, sel_bad;
    logic [CAUSE_W-1:0] sel_cause;
    logic [XLEN-1:0]    vec;
    logic [XLEN-1:0]    epc_nxt, sr_nxt;
    logic [PMR_W-1:0]   pmr_nxt;
    logic               dsx_q;

    exc_cause_sel #(
        .CAUSE_W     (CAUSE_W),
        .CAUSE_COUNT (CAUSE_COUNT)
    ) u_sel (
        .exc_req   (exc_req),
        .exc_cause (exc_cause),
        .irq_ext   (irq_ext),
        .irq_tick  (irq_tick),
        .sr_iee    (cur_sr[SRB_IEE]),
        .sr_tee    (cur_sr[SRB_TEE]),
        .sel_fire  (sel_fire),
        .sel_bad   (sel_bad),
        .sel_cause (sel_cause)
    );

    exc_vector_gen #(
        .XLEN      (XLEN),
        .CAUSE_W   (CAUSE_W),
        .VEC_SHIFT (VEC_SHIFT),
        .HI_PREFIX (HI_PREFIX)
    ) u_vec (
        .cause   (sel_cause),
        .base    (vec_base),
        .base_en (vec_base_en),
        .hivec   (cur_sr[SRB_HIVEC]),
        .vec     (vec)
    );

    exc_state_upd #(
        .XLEN  (XLEN),
        .PMR_W (PMR_W)
    ) u_upd (
        .pc         (cur_pc),
        .sr         (cur_sr),
        .pmr        (cur_pmr),
        .dslot      (in_dslot),
        .is_syscall (sel_cause == C_SYS),
        .epc_nxt    (epc_nxt),
        .sr_nxt     (sr_nxt),
        .pmr_nxt    (pmr_nxt)
    );

    // next-state selection: ACCEPT, REJECT or QUIET from any state
    always_comb begin
        if (sel_fire)     state_d = ST_TAKEN;
        else if (sel_bad) state_d = ST_FAULT;
        else              state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured entry data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_cause <= '0;
            new_pc      <= '0;
            epcr        <= '0;
            eear        <= '0;
            esr         <= '0;
            sr_new      <= '0;
            pmr_new     <= '0;
            dsx_q       <= 1'b0;
        end else if (sel_fire) begin
            taken_cause <= sel_cause;
            new_pc      <= vec;
            epcr        <= epc_nxt;
            esr         <= cur_sr;
            sr_new      <= sr_nxt;
            pmr_new     <= pmr_nxt;
            dsx_q       <= in_dslot;
            if (sel_cause == C_ILL) eear <= cur_pc;
        end
    end

    // state-decoded pulses
    always_comb begin
        exc_taken   = 1'b0;
        exc_err     = 1'b0;
        resv_kill   = 1'b0;
        dslot_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_TAKEN: begin
                exc_taken   = 1'b1;
                resv_kill   = 1'b1;
                dslot_clear = dsx_q;
            end
            ST_FAULT: exc_err = 1'b1;
            default: ;
        endcase
    end

    AST_ESR_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> esr == $past(cur_sr)); // R3
    AST_EPC_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && !$past(in_dslot) && taken_cause != C_SYS) |-> epcr == $past(cur_pc)); // R1
    AST_SUPERVISOR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (sr_new[SRB_SM] && !sr_new[SRB_IEE] && !sr_new[SRB_TEE])); // R4
    AST_POWER_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (!pmr_new[PMB_DOZE] && !pmr_new[PMB_SLEEP])); // R5
    AST_ERR_KEEPS_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        exc_err |-> epcr == $past(epcr)); // R10
    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && $past(exc_req)) |-> taken_cause == $past(exc_cause)); // R11
    AST_VEC_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && !$past(vec_base_en)) |-> new_pc[VEC_SHIFT-1:0] == '0); // R8

endmodule

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_req;
    logic [3:0]  exc_cause;
    logic [31:0] cur_pc, cur_sr, vec_base;
    logic [7:0]  cur_pmr;
    logic        in_dslot, vec_base_en, irq_ext, irq_tick;
    logic        exc_taken, exc_err, resv_kill, dslot_clear;
    logic [3:0]  taken_cause;
    logic [31:0] new_pc, epcr, eear, esr, sr_new;
    logic [7:0]  pmr_new;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic [3:0]  m_cause;
    logic [31:0] m_pc, m_epc, m_eear, m_esr, m_sr;
    logic [7:0]  m_pmr;
    logic        m_ds;

    always #4 clk = ~clk;

    exc_entry_unit i_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
        .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_pmr(cur_pmr), .in_dslot(in_dslot),
        .vec_base(vec_base), .vec_base_en(vec_base_en), .irq_ext(irq_ext),
        .irq_tick(irq_tick), .exc_taken(exc_taken), .exc_err(exc_err),
        .taken_cause(taken_cause), .new_pc(new_pc), .epcr(epcr), .eear(eear),
        .esr(esr), .sr_new(sr_new), .pmr_new(pmr_new), .resv_kill(resv_kill),
        .dslot_clear(dslot_clear)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input logic ef, input logic eb);
        chk("R11 exc_taken", 32'(exc_taken), 32'(ef));
        chk("R10 exc_err", 32'(exc_err), 32'(eb));
        chk("R6 resv_kill", 32'(resv_kill), 32'(ef));
        chk("R7 dslot_clear", 32'(dslot_clear), 32'(ef & m_ds));
        chk("R11 taken_cause", 32'(taken_cause), 32'(m_cause));
        chk("R8 new_pc", new_pc, m_pc);
        chk("R1 epcr", epcr, m_epc);
        chk("R2 eear", eear, m_eear);
        chk("R3 esr", esr, m_esr);
        chk("R4 sr_new", sr_new, m_sr);
        chk("R5 pmr_new", 32'(pmr_new), 32'(m_pmr));
    endtask

    task automatic apply(input logic req, input logic [3:0] c, input logic [31:0] pc,
                         input logic [31:0] sr, input logic [7:0] pmr, input logic ds,
                         input logic [31:0] base, input logic ben,
                         input logic ext, input logic tick);
        logic ef, eb;
        logic [3:0] ec;
        @(negedge clk);
        exc_req = req; exc_cause = c; cur_pc = pc; cur_sr = sr; cur_pmr = pmr;
        in_dslot = ds; vec_base = base; vec_base_en = ben; irq_ext = ext; irq_tick = tick;
        ef = 1'b0; eb = 1'b0; ec = 4'd0;
        if (req) begin
            if (c >= 4'd1 && c <= 4'd14) begin ef = 1'b1; ec = c; end
            else eb = 1'b1;
        end else if (tick && sr[1]) begin ef = 1'b1; ec = 4'd5; end
        else if (ext && sr[2]) begin ef = 1'b1; ec = 4'd8; end
        if (ef) begin
            m_cause = ec;
            m_pc = ({28'd0, ec} << 8) | (ben ? base : 32'd0) | (sr[5] ? 32'hF000_0000 : 32'd0);
            m_epc = pc + ((ec == 4'd12) ? 32'd4 : 32'd0) - (ds ? 32'd4 : 32'd0);
            m_esr = sr;
            m_sr = (sr & ~32'h5E) | 32'h1 | (ds ? 32'h40 : 32'h0);
            m_pmr = pmr & ~8'h03;
            m_ds = ds;
            if (ec == 4'd7) m_eear = pc;
        end
        @(posedge clk); #1;
        check_all(ef, eb);
        @(negedge clk);
        exc_req = 1'b0; irq_ext = 1'b0; irq_tick = 1'b0;
        @(posedge clk); #1;
        check_all(1'b0, 1'b0); // R11 pulse is one cycle wide
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; exc_req = 1'b0; exc_cause = '0; cur_pc = '0; cur_sr = '0;
        cur_pmr = '0; in_dslot = 1'b0; vec_base = '0; vec_base_en = 1'b0;
        irq_ext = 1'b0; irq_tick = 1'b0;
        m_cause = '0; m_pc = '0; m_epc = '0; m_eear = '0; m_esr = '0; m_sr = '0;
        m_pmr = '0; m_ds = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_all(1'b0, 1'b0); // R12 reset state
        @(negedge clk); rst_n = 1'b1;

        // sweep every cause code over base, high-vector and delay-slot settings
        for (int c = 0; c < 16; c++) begin
            for (int cfg = 0; cfg < 8; cfg++) begin
                logic [31:0] sr;
                sr = 32'hC3A5_F09F ^ {24'd0, 4'(c), 4'(cfg)};
                sr[5] = cfg[1];
                apply(1'b1, 4'(c), 32'h0040_1000 + 32'(c * 64 + cfg * 4),
                      sr, 8'hF7 ^ 8'(cfg), cfg[2], 32'h1234_0000 | 32'(cfg), cfg[0],
                      1'b0, 1'b0);
            end
        end

        // R9 interrupt arbitration over every pending/enable combination
        for (int m = 0; m < 16; m++) begin
            logic [31:0] sr;
            sr = 32'h0000_8000;
            sr[2] = m[2];
            sr[1] = m[3];
            apply(1'b0, 4'd0, 32'h0000_2000 + 32'(m * 4), sr, 8'h03, m[0] & m[1],
                  32'h0, 1'b0, m[0], m[1]);
        end

        // R11 synchronous request beats enabled interrupts
        apply(1'b1, 4'd2, 32'h0000_3000, 32'h0000_0006, 8'h00, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
        // R10 invalid cause beats enabled interrupts and leaves state
        apply(1'b1, 4'd15, 32'h0000_3100, 32'h0000_0006, 8'h00, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
        // R2 illegal with delay slot: eear keeps the uncorrected PC, R7 epcr -4
        apply(1'b1, 4'd7, 32'h0000_3200, 32'h0000_0000, 8'h00, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule